// File: doc/BRIEF.md
# Settable Time-of-Day Counter

This block keeps the time of day as four binary fields: hours, minutes, seconds and a millisecond count. In run mode a one-cycle tick enable advances the millisecond field. Each roll-over of a lower field passes a carry into the field above it, from milliseconds up to hours, and hours roll back to zero after 23.

A 2-bit selector switches the block into one of three adjust modes. In an adjust mode, up and down pulses step only the chosen field, and that field wraps at both ends. No carry leaves it, and the tick is ignored, so time stands still while it is being set. The selector is registered into a small mode state machine before it acts.

The four states are RUN, SET_HR, SET_MIN and SET_SEC. On every clock the machine moves from whatever state it is in to the state that the selector names. That transition is the only one it has. The caller produces clean single-cycle up, down and tick strobes. The host command decoding and the display encoding sit outside this block.

Top module: `timekeeper_core`

## Requirements
- R1: While `rst_n` is low, all four fields are driven to 0 and the mode state is RUN.
- R2: The selector is encoded as 0 = RUN, 1 = SET_HR, 2 = SET_MIN and 3 = SET_SEC. The selector value sampled at one clock edge sets the mode that is used at the next edge.
- R3: In RUN, each clock with `tick_i` high adds one to the millisecond field. When the field holds `MS_LAST`, it goes to 0 and seconds advance by one.
- R4: The carry chain works as follows. When seconds roll over from 59, they go to 0 and minutes advance. When minutes roll over from 59, they go to 0 and hours advance. When hours roll over from 23, they go to 0. So 23:59:59 with the millisecond field at `MS_LAST` becomes 00:00:00.0 after one tick.
- R5: In an adjust mode, up on a field that holds its maximum wraps it to 0. The maximum is 23 for hours and 59 for minutes and seconds. The wrap does not carry into any other field.
- R6: In an adjust mode, down on a field that holds 0 wraps it to its maximum (23 or 59).
- R7: When up and down are both high in an adjust mode, the step is upward and down is ignored.
- R8: In an adjust mode `tick_i` has no effect, and the millisecond field holds. In RUN, `up_i` and `down_i` have no effect.
- R9: In an adjust mode, the selected field moves by exactly one for each clock in which up or down is high, and every other field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 2 | Mode select: 0 run, 1 hours, 2 minutes, 3 seconds |
| up_i | input | 1 | Step the selected field upward (adjust modes only) |
| down_i | input | 1 | Step the selected field downward (adjust modes only) |
| tick_i | input | 1 | Millisecond tick enable (run mode only) |
| hr_o | output | FIELD_W (8) | Hours, binary 0..23 |
| min_o | output | FIELD_W (8) | Minutes, binary 0..59 |
| sec_o | output | FIELD_W (8) | Seconds, binary 0..59 |
| ms_o | output | MS_W (10) | Millisecond count, binary 0..MS_LAST |

## Verification
The bench builds the block with `MS_LAST` = 9 and keeps the 8-bit and 10-bit field widths. A second therefore lasts ten ticks, which brings the seconds and minutes carries, and the full 23:59:59 to midnight rollover, within a few cycles of a state reached by adjusting. Random traffic can then cross the carry boundaries many times within the cycle budget. With the default of 999, a single minute carry would need about sixty thousand ticks.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int HR_LAST = 23;
    localparam int MS_LAST_MIN_SEC = 59;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SET_HR  = 2'd1,
        ST_SET_MIN = 2'd2,
        ST_SET_SEC = 2'd3
    } tk_mode_e;

endpackage

// File: rtl/tk_mode_fsm.sv
module tk_mode_fsm
    import tk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    output tk_mode_e   state_q,
    output logic       run_en,
    output logic       adj_hr,
    output logic       adj_min,
    output logic       adj_sec
);

    tk_mode_e state_d;

    // next state: the selector names the target state
    always_comb begin
        unique case (sel_i)
            2'd0:    state_d = ST_RUN;
            2'd1:    state_d = ST_SET_HR;
            2'd2:    state_d = ST_SET_MIN;
            default: state_d = ST_SET_SEC;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // decoded state outputs
    always_comb begin
        run_en  = 1'b0;
        adj_hr  = 1'b0;
        adj_min = 1'b0;
        adj_sec = 1'b0;
        unique case (state_q)
            ST_RUN:     run_en  = 1'b1;
            ST_SET_HR:  adj_hr  = 1'b1;
            ST_SET_MIN: adj_min = 1'b1;
            ST_SET_SEC: adj_sec = 1'b1;
            default:    run_en  = 1'b0;
        endcase
    end

endmodule

// File: rtl/tk_wrap_counter.sv
module tk_wrap_counter #(
    parameter int W    = 8,
    parameter int LAST = 59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] TOP = W'(LAST);

    // increment has priority over decrement; both wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (inc) begin
            value <= (value == TOP) ? '0 : value + 1'b1;
        end else if (dec) begin
            value <= (value == '0) ? TOP : value - 1'b1;
        end
    end

endmodule

// File: rtl/timekeeper_core.sv
module timekeeper_core
    import tk_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int MS_W    = 10,
    parameter int MS_LAST = 999
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         sel_i,
    input  logic               up_i,
    input  logic               down_i,
    input  logic               tick_i,
    output logic [FIELD_W-1:0] hr_o,
    output logic [FIELD_W-1:0] min_o,
    output logic [FIELD_W-1:0] sec_o,
    output logic [MS_W-1:0]    ms_o
);

    localparam logic [MS_W-1:0]    MS_TOP  = MS_W'(MS_LAST);
    localparam logic [FIELD_W-1:0] SM_TOP  = FIELD_W'(MS_LAST_MIN_SEC);

    tk_mode_e mode_q;
    logic     run_en, adj_hr, adj_min, adj_sec;
    logic     step_up, step_dn;
    logic     ms_inc, ms_roll, sec_roll, min_roll;
    logic     sec_inc, sec_dec, min_inc, min_dec, hr_inc, hr_dec;

    tk_mode_fsm u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel_i),
        .state_q (mode_q),
        .run_en  (run_en),
        .adj_hr  (adj_hr),
        .adj_min (adj_min),
        .adj_sec (adj_sec)
    );

    // up wins over down
    assign step_up = up_i;
    assign step_dn = down_i & ~up_i;

    // cascaded carries exist only in run mode
    assign ms_inc   = run_en & tick_i;
    assign ms_roll  = ms_inc & (ms_o == MS_TOP);
    assign sec_roll = ms_roll & (sec_o == SM_TOP);
    assign min_roll = sec_roll & (min_o == SM_TOP);

    assign sec_inc = ms_roll  | (adj_sec & step_up);
    assign sec_dec = adj_sec & step_dn;
    assign min_inc = sec_roll | (adj_min & step_up);
    assign min_dec = adj_min & step_dn;
    assign hr_inc  = min_roll | (adj_hr & step_up);
    assign hr_dec  = adj_hr & step_dn;

    tk_wrap_counter #(.W(MS_W), .LAST(MS_LAST)) u_ms (
        .clk (clk), .rst_n (rst_n), .inc (ms_inc), .dec (1'b0), .value (ms_o)
    );

    tk_wrap_counter #(.W(FIELD_W), .LAST(MS_LAST_MIN_SEC)) u_sec (
        .clk (clk), .rst_n (rst_n), .inc (sec_inc), .dec (sec_dec), .value (sec_o)
    );

    tk_wrap_counter #(.W(FIELD_W), .LAST(MS_LAST_MIN_SEC)) u_min (
        .clk (clk), .rst_n (rst_n), .inc (min_inc), .dec (min_dec), .value (min_o)
    );

    tk_wrap_counter #(.W(FIELD_W), .LAST(HR_LAST)) u_hr (
        .clk (clk), .rst_n (rst_n), .inc (hr_inc), .dec (hr_dec), .value (hr_o)
    );

endmodule

// File: rtl/tk_checker.sv
module tk_checker
    import tk_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int MS_W    = 10,
    parameter int MS_LAST = 999
) (
    input logic               clk,
    input logic               rst_n,
    input logic               up_i,
    input logic               down_i,
    input logic               tick_i,
    input tk_mode_e           mode_q,
    input logic [FIELD_W-1:0] hr_o,
    input logic [FIELD_W-1:0] min_o,
    input logic [FIELD_W-1:0] sec_o,
    input logic [MS_W-1:0]    ms_o
);

    a_r4_hour_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        hr_o <= FIELD_W'(HR_LAST));

    a_r3_ms_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ms_o <= MS_W'(MS_LAST));

    a_r8_adjust_freezes_ms: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != ST_RUN) |=> $stable(ms_o));

    a_r5_hour_wraps_up: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_SET_HR && up_i && hr_o == FIELD_W'(HR_LAST)) |=> (hr_o == '0));

    a_r6_minute_wraps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_SET_MIN && down_i && !up_i && min_o == '0)
        |=> (min_o == FIELD_W'(MS_LAST_MIN_SEC)));

    a_r7_up_beats_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_SET_SEC && up_i && down_i && sec_o < FIELD_W'(MS_LAST_MIN_SEC))
        |=> (sec_o == $past(sec_o) + 1'b1));

    a_r4_second_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_RUN && tick_i && ms_o == MS_W'(MS_LAST)
         && sec_o == FIELD_W'(MS_LAST_MIN_SEC) && min_o < FIELD_W'(MS_LAST_MIN_SEC))
        |=> (sec_o == '0 && min_o == $past(min_o) + 1'b1));

    a_r9_run_ignores_buttons: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_RUN && !tick_i) |=> ($stable(hr_o) && $stable(min_o) && $stable(sec_o)));

endmodule

bind timekeeper_core tk_checker #(
    .FIELD_W (FIELD_W),
    .MS_W    (MS_W),
    .MS_LAST (MS_LAST)
) u_tk_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_i   (up_i),
    .down_i (down_i),
    .tick_i (tick_i),
    .mode_q (mode_q),
    .hr_o   (hr_o),
    .min_o  (min_o),
    .sec_o  (sec_o),
    .ms_o   (ms_o)
);

// File: tb/timekeeper_core_bench.sv
module timekeeper_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int FW  = 8;
    localparam int MW  = 10;
    localparam int MSL = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    sel = 2'd0;
    logic          up = 1'b0, dn = 1'b0, tick = 1'b0;
    logic [FW-1:0] hr, mn, sc;
    logic [MW-1:0] ms;

    int n_checks = 0;
    int n_fail   = 0;
    int m_hr = 0, m_min = 0, m_sec = 0, m_ms = 0, m_mode = 0;

    timekeeper_core #(.FIELD_W(FW), .MS_W(MW), .MS_LAST(MSL)) u_timekeeper_core (
        .clk (clk), .rst_n (rst_n), .sel_i (sel), .up_i (up), .down_i (dn),
        .tick_i (tick), .hr_o (hr), .min_o (mn), .sec_o (sc), .ms_o (ms)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int wrap_step(int v, int top, logic u, logic d);
        if (u)      return (v == top) ? 0 : v + 1;
        else if (d) return (v == 0) ? top : v - 1;
        return v;
    endfunction

    // reference model built from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hr = 0; m_min = 0; m_sec = 0; m_ms = 0; m_mode = 0;
        end else begin
            case (m_mode)
                0: if (tick) begin
                    if (m_ms == MSL) begin
                        m_ms = 0;
                        if (m_sec == 59) begin
                            m_sec = 0;
                            if (m_min == 59) begin
                                m_min = 0;
                                m_hr  = (m_hr == 23) ? 0 : m_hr + 1;
                            end else m_min = m_min + 1;
                        end else m_sec = m_sec + 1;
                    end else m_ms = m_ms + 1;
                end
                1: m_hr  = wrap_step(m_hr, 23, up, dn);
                2: m_min = wrap_step(m_min, 59, up, dn);
                default: m_sec = wrap_step(m_sec, 59, up, dn);
            endcase
            m_mode = int'(sel);
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all(string tag);
        check(tag, int'(hr), m_hr);
        check(tag, int'(mn), m_min);
        check(tag, int'(sc), m_sec);
        check(tag, int'(ms), m_ms);
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        @(negedge clk);
        cmp_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset hr", int'(hr), 0);
        check("R1 reset min", int'(mn), 0);
        check("R1 reset sec", int'(sc), 0);
        check("R1 reset ms", int'(ms), 0);
        rst_n = 1'b1;

        // R2: select hours, then step up through the range
        sel = 2'd1; cyc("R2 select");
        up = 1'b1;
        for (int i = 0; i < 23; i++) cyc("R9 hour step");
        check("R9 hour at top", int'(hr), 23);
        cyc("R5 hour wrap");
        check("R5 hour wraps to 0", int'(hr), 0);
        up = 1'b0; dn = 1'b1; cyc("R6 hour down");
        check("R6 hour wraps to 23", int'(hr), 23);
        dn = 1'b0; sel = 2'd2; cyc("R2 select min");
        dn = 1'b1; cyc("R6 min down");
        check("R6 min wraps to 59", int'(mn), 59);
        dn = 1'b0; sel = 2'd3; cyc("R2 select sec");
        dn = 1'b1; cyc("R6 sec down");
        check("R6 sec wraps to 59", int'(sc), 59);
        up = 1'b1; cyc("R7 both pressed");
        check("R7 up wins, sec", int'(sc), 0);
        check("R5 no carry into min", int'(mn), 59);
        up = 1'b0; cyc("R6 sec down again");
        dn = 1'b0;
        tick = 1'b1;
        for (int i = 0; i < 4; i++) cyc("R8 tick in adjust");
        check("R8 ms frozen", int'(ms), 0);
        tick = 1'b0; sel = 2'd0; cyc("R2 select run");
        up = 1'b1; dn = 1'b1;
        for (int i = 0; i < 2; i++) cyc("R8 buttons in run");
        check("R8 sec unchanged", int'(sc), 59);
        check("R8 hr unchanged", int'(hr), 23);
        up = 1'b0; dn = 1'b0; tick = 1'b1;
        for (int i = 0; i < MSL; i++) cyc("R3 ms count");
        check("R3 ms at last", int'(ms), MSL);
        cyc("R4 midnight");
        check("R4 hr to 0", int'(hr), 0);
        check("R4 min to 0", int'(mn), 0);
        check("R4 sec to 0", int'(sc), 0);
        check("R4 ms to 0", int'(ms), 0);

        // random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            sel  = (r < 55) ? 2'd0 : 2'($urandom_range(1, 3));
            tick = ($urandom_range(0, 9) < 8);
            up   = ($urandom_range(0, 9) < 3);
            dn   = ($urandom_range(0, 9) < 3);
            cyc("R9 random");
        end
        up = 1'b0; dn = 1'b0; tick = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule